// File: doc/BRIEF.md
# Power-Gating Domain Request Controller

This block switches a set of on-chip power domains off and on at the request of software. Software talks to it over a simple word bus: address, write enable, write data and combinational read data. Each domain gets a power-switch enable output, an isolation output, and an active-low request output toward the bus bridge in front of it. A matching active-low acknowledge input comes back from that bridge. A small sequencer per domain drives these outputs in a safe order. A counter in each sequencer stands in for the settling time of the analog switch.

A domain takes software requests only after it has been assigned to the processor through the mapping register. It can be turned off only while its own power-control enable bit is set. A request bit stays set while its sequence runs and clears by itself when the sequence ends. Software can therefore poll the bit to see when the work is done. One domain uses two bits in every field. Another domain has no switch at all and is driven only through the handshake register.

The default build has four domains:

| Domain | Request and mapping bits | Handshake request bits | Acknowledge bits | Control register | Status register |
|--------|--------------------------|------------------------|------------------|------------------|-----------------|
| 0 | bit 0 | none | none | 0xC00 | 0xC0C |
| 1 | bit 1 | bit 1 | bit 17 | 0xC40 | 0xC4C |
| 2 | bits 2 and 5 | bits 2 and 3 | bits 18 and 19 | 0xC80 | 0xC8C |
| 3 | none | bit 4 | bit 20 | none | none |

Top module: `pgc_ctrl`

## Requirements
- R1: After reset, every domain has `pwr_sw_en`=1, `iso_en`=0 and `hsk_req_n`=1. The mapping register, both request registers and the control registers read 0. Each status register reads 1. The handshake register reads 1 on every handshake request bit that a domain owns.
- R2: The mapping register is at 0x0EC. A domain's mapping field becomes 1 when a write to this register sets any of the domain's bits, and 0 otherwise. A power-up or power-down request for a domain whose mapping field is 0 is ignored: its request bits read 0 and no output changes.
- R3: Writing 1 to any bit of a mapped domain starts that domain's sequence. Power-up requests go to 0x0F8 and power-down requests go to 0x104. All of the domain's bits in that register read 1 from the cycle after the write, and return to 0 on their own when the sequence completes.
- R4: The control register of domain d is at 0x800 + (16+d)*0x40, and bit 0 is the power-control enable. A power-down request made while this enable is 0 clears after one cycle, and no output changes.
- R5: A power-down runs in this order: drop `hsk_req_n` (handshake domains only), wait for `hsk_ack_n`=0, raise `iso_en` for one cycle, then drop `pwr_sw_en` for SETTLE cycles. The request clears SETTLE+3 clock edges after the write edge for a domain with a handshake, and SETTLE+2 edges after it for a domain without one.
- R6: A power-up runs in this order: raise `pwr_sw_en` while isolation is still on, hold for SETTLE cycles, drop `iso_en` for one cycle, then raise `hsk_req_n`. The request clears SETTLE+2 edges after the write edge.
- R7: Bit 0 of each status register, at the control address plus 0x0C, reads 1 exactly when the domain is fully powered and idle.
- R8: For a domain with two bits in a field, writing either bit acts on the domain. Both bits always read back with the same value.
- R9: A domain with no request bits has no control or status register. Its `pwr_sw_en` stays at 1 and its `iso_en` at 0. Its `hsk_req_n` follows its handshake request bits in the handshake register at 0x1FC from the cycle after the write.
- R10: Bits 31:16 of the handshake register show each handshake domain's `hsk_ack_n` input at its request bit positions plus 16. Writes to those bits are ignored.
- R11: If a power-down request is pending while a power-up is pending or running, the power-up wins. Both requests clear when the power-up completes, and the domain stays on.
- R12: Any address that is not a defined register reads 0, and writes to it change no state and no output.
- R13: A request for the state the domain is already in clears one cycle after the write, with no output change.
- R14: During a power-down, `iso_en` and `pwr_sw_en` do not change while `hsk_ack_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pwr_sw_en | output | NUM_DOM | Power switch closed (1) per domain |
| iso_en | output | NUM_DOM | Isolation clamps active per domain |
| hsk_req_n | output | NUM_DOM | Handshake request per domain, low asks for power-down |
| hsk_ack_n | input | NUM_DOM | Handshake acknowledge per domain, low grants power-down |

## Verification
Read data is combinational, so the bench reads it within the same cycle, half a period after the write edge. Register fields change on the write edge, and request bits clear exactly one edge after the write when no sequence runs. Sequence outputs are due a fixed number of edges after the write edge. The bench computes these counts with its own latency functions from SETTLE and from whether the domain has a handshake. It samples every result on the falling edge after the edge in which the result is due, and checks the request bit one edge earlier to prove the sequence is not early. The acknowledge model follows `hsk_req_n` on each falling edge, so a handshake costs exactly one edge. The model can also hold the acknowledge high for as long as the bench needs.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int FIELD_W = 16;

  localparam logic [ADDR_W-1:0] OFS_MAP        = 12'h0EC;
  localparam logic [ADDR_W-1:0] OFS_UP         = 12'h0F8;
  localparam logic [ADDR_W-1:0] OFS_DN         = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_HSK        = 12'h1FC;
  localparam logic [ADDR_W-1:0] OFS_DOM_BASE   = 12'h800;
  localparam logic [ADDR_W-1:0] OFS_DOM_STRIDE = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_STAT       = 12'h00C;

  typedef enum logic [2:0] {
    ST_ON, ST_DN_HSK, ST_DN_ISO, ST_DN_SW, ST_OFF, ST_UP_SW, ST_UP_ISO
  } seq_state_e;

  // address of the control register for one switch slot
  function automatic logic [ADDR_W-1:0] dom_ctrl_addr(input int slot);
    return OFS_DOM_BASE + ADDR_W'(slot) * OFS_DOM_STRIDE;
  endfunction

  // a multi-bit field acts when any of its bits is written 1
  function automatic logic field_hit(input logic [FIELD_W-1:0] data,
                                     input logic [FIELD_W-1:0] mask);
    return |(data & mask);
  endfunction

  // spread a per-domain flag over all bits the domain owns
  function automatic logic [FIELD_W-1:0] field_fill(input logic flag,
                                                    input logic [FIELD_W-1:0] mask);
    return flag ? mask : '0;
  endfunction
endpackage

// File: rtl/pgc_addr_dec.sv
module pgc_addr_dec
  import pgc_pkg::*;
#(
  parameter int                    NUM_DOM   = 4,
  parameter logic [NUM_DOM*16-1:0] REQ_MASKS = '0,
  parameter int                    SLOT_BASE = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_map,
  output logic              sel_up,
  output logic              sel_dn,
  output logic              sel_hsk,
  output logic [NUM_DOM-1:0] sel_ctrl,
  output logic [NUM_DOM-1:0] sel_stat,
  output logic              hit
);
  assign sel_map = (addr == OFS_MAP);
  assign sel_up  = (addr == OFS_UP);
  assign sel_dn  = (addr == OFS_DN);
  assign sel_hsk = (addr == OFS_HSK);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    if (REQ_MASKS[d*16 +: 16] != '0) begin : g_pgc
      localparam logic [ADDR_W-1:0] CTRL_A = dom_ctrl_addr(SLOT_BASE + d);
      assign sel_ctrl[d] = (addr == CTRL_A);
      assign sel_stat[d] = (addr == CTRL_A + OFS_STAT);
    end else begin : g_none
      assign sel_ctrl[d] = 1'b0;
      assign sel_stat[d] = 1'b0;
    end
  end

  assign hit = sel_map | sel_up | sel_dn | sel_hsk | (|sel_ctrl) | (|sel_stat);
endmodule

// File: rtl/pgc_dom_seq.sv
module pgc_dom_seq
  import pgc_pkg::*;
#(
  parameter bit HAS_HSK = 1'b1,
  parameter int SETTLE  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_pend,
  input  logic dn_pend,
  input  logic pwr_ctl_en,
  input  logic hsk_ack_n,
  output logic clr_up,
  output logic clr_dn,
  output logic powered,
  output logic sw_en,
  output logic iso,
  output logic hsk_ok
);
  localparam int               CNT_W    = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE - 1);

  seq_state_e       state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    clr_up   = 1'b0;
    clr_dn   = 1'b0;
    case (state)
      ST_ON: begin
        if (up_pend) begin
          clr_up = 1'b1;
          clr_dn = 1'b1;
        end else if (dn_pend) begin
          if (pwr_ctl_en) state_nx = HAS_HSK ? ST_DN_HSK : ST_DN_ISO;
          else            clr_dn   = 1'b1;
        end
      end
      ST_DN_HSK: if (!hsk_ack_n) state_nx = ST_DN_ISO;
      ST_DN_ISO: begin
        state_nx = ST_DN_SW;
        cnt_nx   = CNT_LOAD;
      end
      ST_DN_SW: begin
        if (cnt == '0) begin
          state_nx = ST_OFF;
          clr_dn   = 1'b1;
        end else cnt_nx = cnt - 1'b1;
      end
      ST_OFF: begin
        if (up_pend) begin
          state_nx = ST_UP_SW;
          cnt_nx   = CNT_LOAD;
        end else if (dn_pend) clr_dn = 1'b1;
      end
      ST_UP_SW: begin
        if (cnt == '0) state_nx = ST_UP_ISO;
        else           cnt_nx   = cnt - 1'b1;
      end
      ST_UP_ISO: begin
        state_nx = ST_ON;
        clr_up   = 1'b1;
        clr_dn   = 1'b1;
      end
      default: state_nx = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_ON;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  assign powered = (state == ST_ON);
  assign hsk_ok  = (state == ST_ON);
  assign sw_en   = !((state == ST_DN_SW) || (state == ST_OFF));
  assign iso     = (state == ST_DN_ISO) || (state == ST_DN_SW) ||
                   (state == ST_OFF)    || (state == ST_UP_SW);
endmodule

// File: rtl/pgc_ctrl.sv
module pgc_ctrl
  import pgc_pkg::*;
#(
  parameter int                    NUM_DOM   = 4,
  parameter logic [NUM_DOM*16-1:0] REQ_MASKS = 64'h0000_0024_0002_0001,
  parameter logic [NUM_DOM*16-1:0] HSK_MASKS = 64'h0010_000C_0002_0000,
  parameter int                    SLOT_BASE = 16,
  parameter int                    SETTLE    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_DOM-1:0] pwr_sw_en,
  output logic [NUM_DOM-1:0] iso_en,
  output logic [NUM_DOM-1:0] hsk_req_n,
  input  logic [NUM_DOM-1:0] hsk_ack_n
);
  logic               sel_map, sel_up, sel_dn, sel_hsk, addr_hit;
  logic [NUM_DOM-1:0] sel_ctrl, sel_stat;
  logic [NUM_DOM-1:0] map_flag, up_pend, dn_pend, pcr, hs_sw;
  logic [NUM_DOM-1:0] clr_up, clr_dn, powered, seq_hsk_ok;
  logic [FIELD_W-1:0] wdata_lo;
  logic               unused_wdata_hi;

  assign wdata_lo        = bus_wdata[FIELD_W-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:FIELD_W];

  pgc_addr_dec #(
    .NUM_DOM(NUM_DOM), .REQ_MASKS(REQ_MASKS), .SLOT_BASE(SLOT_BASE)
  ) u_dec (
    .addr(bus_addr), .sel_map(sel_map), .sel_up(sel_up), .sel_dn(sel_dn),
    .sel_hsk(sel_hsk), .sel_ctrl(sel_ctrl), .sel_stat(sel_stat), .hit(addr_hit)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    localparam logic [FIELD_W-1:0] RM = REQ_MASKS[d*16 +: 16];
    localparam logic [FIELD_W-1:0] HM = HSK_MASKS[d*16 +: 16];

    logic map_q, up_q, dn_q, pcr_q, hs_q;
    logic set_up, set_dn;
    logic sw, iso, ok;

    assign set_up = bus_we & sel_up & map_q & field_hit(wdata_lo, RM);
    assign set_dn = bus_we & sel_dn & map_q & field_hit(wdata_lo, RM);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q <= 1'b0;
        up_q  <= 1'b0;
        dn_q  <= 1'b0;
        pcr_q <= 1'b0;
        hs_q  <= 1'b1;
      end else begin
        if (bus_we && sel_map)                 map_q <= field_hit(wdata_lo, RM);
        up_q <= (up_q & ~clr_up[d]) | set_up;
        dn_q <= (dn_q & ~clr_dn[d]) | set_dn;
        if (bus_we && sel_ctrl[d])             pcr_q <= bus_wdata[0];
        if (bus_we && sel_hsk && HM != '0)     hs_q  <= field_hit(wdata_lo, HM);
      end
    end

    pgc_dom_seq #(.HAS_HSK(HM != '0), .SETTLE(SETTLE)) u_seq (
      .clk(clk), .rst_n(rst_n), .up_pend(up_q), .dn_pend(dn_q),
      .pwr_ctl_en(pcr_q), .hsk_ack_n(hsk_ack_n[d]),
      .clr_up(clr_up[d]), .clr_dn(clr_dn[d]), .powered(powered[d]),
      .sw_en(sw), .iso(iso), .hsk_ok(ok)
    );

    assign map_flag[d]   = map_q;
    assign up_pend[d]    = up_q;
    assign dn_pend[d]    = dn_q;
    assign pcr[d]        = pcr_q;
    assign hs_sw[d]      = hs_q;
    assign seq_hsk_ok[d] = ok;
    assign pwr_sw_en[d]  = sw;
    assign iso_en[d]     = iso;
    assign hsk_req_n[d]  = hs_q & ok;
  end

  always_comb begin
    bus_rdata = '0;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (sel_map)
        bus_rdata[FIELD_W-1:0] = bus_rdata[FIELD_W-1:0] | field_fill(map_flag[d], REQ_MASKS[d*16 +: 16]);
      if (sel_up)
        bus_rdata[FIELD_W-1:0] = bus_rdata[FIELD_W-1:0] | field_fill(up_pend[d], REQ_MASKS[d*16 +: 16]);
      if (sel_dn)
        bus_rdata[FIELD_W-1:0] = bus_rdata[FIELD_W-1:0] | field_fill(dn_pend[d], REQ_MASKS[d*16 +: 16]);
      if (sel_hsk) begin
        bus_rdata[FIELD_W-1:0] = bus_rdata[FIELD_W-1:0] | field_fill(hs_sw[d], HSK_MASKS[d*16 +: 16]);
        bus_rdata[DATA_W-1:FIELD_W] = bus_rdata[DATA_W-1:FIELD_W] |
                                      field_fill(hsk_ack_n[d], HSK_MASKS[d*16 +: 16]);
      end
      if (sel_ctrl[d]) bus_rdata[0] = bus_rdata[0] | pcr[d];
      if (sel_stat[d]) bus_rdata[0] = bus_rdata[0] | powered[d];
    end
  end
endmodule

// File: rtl/pgc_ctrl_chk.sv
module pgc_ctrl_chk #(
  parameter int                    NUM_DOM   = 4,
  parameter logic [NUM_DOM*16-1:0] HSK_MASKS = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DOM-1:0] pwr_sw_en,
  input logic [NUM_DOM-1:0] iso_en,
  input logic [NUM_DOM-1:0] hsk_req_n,
  input logic [NUM_DOM-1:0] hsk_ack_n,
  input logic [31:0]        bus_rdata,
  input logic               addr_hit
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    // R5
    iso_before_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_sw_en[d]) |-> $past(iso_en[d]));
    // R5
    open_needs_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_sw_en[d] |-> iso_en[d]);
    // R6
    release_when_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso_en[d]) |-> (pwr_sw_en[d] && $past(pwr_sw_en[d])));
    // R6
    hsk_high_only_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hsk_req_n[d] |-> (pwr_sw_en[d] && !iso_en[d]));
    if (HSK_MASKS[d*16 +: 16] != '0) begin : g_hsk
      // R14
      iso_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_en[d]) |-> (!hsk_req_n[d] && !$past(hsk_ack_n[d])));
    end
  end

  // R12
  undef_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata != '0) |-> addr_hit);
endmodule

bind pgc_ctrl pgc_ctrl_chk #(.NUM_DOM(NUM_DOM), .HSK_MASKS(HSK_MASKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_sw_en(pwr_sw_en), .iso_en(iso_en),
  .hsk_req_n(hsk_req_n), .hsk_ack_n(hsk_ack_n), .bus_rdata(bus_rdata),
  .addr_hit(addr_hit)
);

// File: tb/pgc_ctrl_bench.sv
module pgc_ctrl_bench;
  localparam int SETTLE = 4;
  localparam logic [15:0] BM [4] = '{16'h0001, 16'h0002, 16'h0024, 16'h0000};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwr_sw_en, iso_en, hsk_req_n;
  logic [3:0]  hsk_ack_n = 4'hF;
  logic [3:0]  ack_hold = 4'h0;
  int          nvec = 0;
  int          nfail = 0;

  always #5 clk = ~clk;

  pgc_ctrl #(.SETTLE(SETTLE)) u_pgc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_sw_en(pwr_sw_en),
    .iso_en(iso_en), .hsk_req_n(hsk_req_n), .hsk_ack_n(hsk_ack_n)
  );

  // bridge model: acknowledge follows the request one falling edge later
  always @(negedge clk)
    for (int d = 0; d < 4; d++)
      if (!ack_hold[d]) hsk_ack_n[d] = hsk_req_n[d];

  function automatic int dn_lat(input bit has_hsk);
    return has_hsk ? SETTLE + 3 : SETTLE + 2;
  endfunction
  function automatic int up_lat();
    return SETTLE + 2;
  endfunction
  function automatic logic [11:0] ctrl_a(input int d);
    return 12'hC00 + 12'(d) * 12'h040;
  endfunction
  function automatic logic [31:0] exp_map(input logic [31:0] w);
    logic [31:0] e = '0;
    for (int d = 0; d < 4; d++)
      if ((w[15:0] & BM[d]) != 0) e[15:0] = e[15:0] | BM[d];
    return e;
  endfunction
  function automatic bit is_defined(input logic [11:0] a);
    return a inside {12'h0EC, 12'h0F8, 12'h104, 12'h1FC,
                     12'hC00, 12'hC0C, 12'hC40, 12'hC4C, 12'hC80, 12'hC8C};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask
  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [3:0]  s_sw, s_iso, s_hs;
    void'($urandom(32'd2024));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state, R7 status
    chk("R1 pwr_sw_en", {28'd0, pwr_sw_en}, 32'hF);
    chk("R1 iso_en", {28'd0, iso_en}, 32'h0);
    chk("R1 hsk_req_n", {28'd0, hsk_req_n}, 32'hF);
    rd(12'h0EC, v); chk("R1 map", v, 0);
    rd(12'h0F8, v); chk("R1 up", v, 0);
    rd(12'h104, v); chk("R1 dn", v, 0);
    rd(12'h1FC, v); chk("R1 R10 hsk reg", v, 32'h001E_001E);
    for (int d = 0; d < 3; d++) begin
      rd(ctrl_a(d), v); chk("R1 ctrl", v, 0);
      rd(ctrl_a(d) + 12'h00C, v); chk("R7 status on", v, 1);
    end

    // R2 unmapped domain ignores requests
    wr(12'h0F8, 32'h1); rd(12'h0F8, v); chk("R2 unmapped up ignored", v, 0);
    wr(12'h104, 32'h3); rd(12'h104, v); chk("R2 unmapped dn ignored", v, 0);
    chk("R2 outputs unchanged", {28'd0, pwr_sw_en}, 32'hF);

    // R2 R8 mapping, writing only bit 2 of the dual domain
    wr(12'h0EC, 32'h0000_0007); rd(12'h0EC, v); chk("R2 R8 map readback", v, exp_map(32'h7));

    // R13 power-up of a domain already on
    wr(12'h0F8, 32'h1); rd(12'h0F8, v); chk("R3 up bit set", v, 32'h1);
    wait_n(1); rd(12'h0F8, v); chk("R13 up clears in one cycle", v, 0);
    chk("R13 no output change", {28'd0, pwr_sw_en, iso_en}, 32'hF0);

    // R4 power-down refused while enable is 0
    wr(12'h104, 32'h1); rd(12'h104, v); chk("R4 dn bit set", v, 32'h1);
    wait_n(1); rd(12'h104, v); chk("R4 dn clears", v, 0);
    chk("R4 domain stays on", {31'd0, pwr_sw_en[0]}, 1);

    // R5 power-down without handshake (domain 0)
    wr(ctrl_a(0), 32'h1); rd(ctrl_a(0), v); chk("R4 enable readback", v, 1);
    wr(12'h104, 32'h1);
    wait_n(1); chk("R5 iso first", {30'd0, pwr_sw_en[0], iso_en[0]}, 32'h3);
    wait_n(dn_lat(0) - 2); rd(12'h104, v); chk("R5 R3 dn busy", v, 32'h1);
    wait_n(1); rd(12'h104, v); chk("R5 R3 dn done", v, 0);
    chk("R5 off state", {30'd0, pwr_sw_en[0], iso_en[0]}, 32'h1);
    rd(ctrl_a(0) + 12'h00C, v); chk("R7 status off", v, 0);

    // R13 power-down of a domain already off
    wr(12'h104, 32'h1); wait_n(1); rd(12'h104, v); chk("R13 dn clears", v, 0);
    chk("R13 stays off", {31'd0, pwr_sw_en[0]}, 0);

    // R6 power-up (domain 0)
    wr(12'h0F8, 32'h1);
    wait_n(1); chk("R6 switch closes under iso", {30'd0, pwr_sw_en[0], iso_en[0]}, 32'h3);
    wait_n(up_lat() - 2); rd(12'h0F8, v); chk("R6 R3 up busy", v, 32'h1);
    chk("R6 iso released, hsk low", {30'd0, iso_en[0], hsk_req_n[0]}, 32'h0);
    wait_n(1); rd(12'h0F8, v); chk("R6 R3 up done", v, 0);
    chk("R6 on state", {29'd0, pwr_sw_en[0], iso_en[0], hsk_req_n[0]}, 32'h5);

    // R5 power-down with handshake (domain 1)
    wr(ctrl_a(1), 32'h1);
    wr(12'h104, 32'h2);
    wait_n(1); chk("R5 hsk drops first", {29'd0, hsk_req_n[1], pwr_sw_en[1], iso_en[1]}, 32'h2);
    wait_n(1); chk("R5 iso after ack", {30'd0, pwr_sw_en[1], iso_en[1]}, 32'h3);
    wait_n(1); chk("R5 switch opens", {30'd0, pwr_sw_en[1], iso_en[1]}, 32'h1);
    wait_n(dn_lat(1) - 4); rd(12'h104, v); chk("R5 hsk dn busy", v, 32'h2);
    wait_n(1); rd(12'h104, v); chk("R5 hsk dn done", v, 0);
    rd(ctrl_a(1) + 12'h00C, v); chk("R7 status dom1 off", v, 0);

    // R6 power-up with handshake (domain 1)
    wr(12'h0F8, 32'h2);
    wait_n(up_lat() - 1); chk("R6 hsk still low", {30'd0, iso_en[1], hsk_req_n[1]}, 32'h0);
    wait_n(1); chk("R6 hsk raised last", {31'd0, hsk_req_n[1]}, 1);

    // R14 R8 stalled acknowledge on the dual domain
    wr(ctrl_a(2), 32'h1);
    ack_hold[2] = 1'b1;
    wr(12'h104, 32'h20); rd(12'h104, v); chk("R8 dual dn readback", v, 32'h24);
    wait_n(20);
    chk("R14 no switch change", {30'd0, pwr_sw_en[2], iso_en[2]}, 32'h2);
    rd(12'h104, v); chk("R14 dn pending", v, 32'h24);
    ack_hold[2] = 1'b0;
    wait_n(SETTLE + 6);
    rd(12'h104, v); chk("R14 dn completes", v, 0);
    chk("R14 dom2 off", {31'd0, pwr_sw_en[2]}, 0);
    wr(12'h0F8, 32'h04);
    wait_n(up_lat()); chk("R8 dual up by bit 2", {31'd0, pwr_sw_en[2] & ~iso_en[2]}, 1);

    // R11 up wins over a later down
    wr(12'h104, 32'h1); wait_n(dn_lat(0));
    chk("R11 prep off", {31'd0, pwr_sw_en[0]}, 0);
    wr(12'h0F8, 32'h1); wr(12'h104, 32'h1);
    wait_n(up_lat() + 1);
    rd(12'h0F8, v); chk("R11 up cleared", v, 0);
    rd(12'h104, v); chk("R11 dn dropped", v, 0);
    wait_n(10);
    chk("R11 stays on", {30'd0, pwr_sw_en[0], iso_en[0]}, 32'h2);

    // R9 R10 handshake-only domain
    wr(12'h1FC, 32'h0000_000E);
    chk("R9 hsk follows sw", {31'd0, hsk_req_n[3]}, 0);
    chk("R9 no switch", {30'd0, pwr_sw_en[3], iso_en[3]}, 32'h2);
    wait_n(1); rd(12'h1FC, v); chk("R10 ack field", v, 32'h000E_000E);
    rd(12'hCC0, v); chk("R9 no ctrl reg", v, 0);
    wr(12'h1FC, 32'hFFFF_0010); rd(12'h1FC, v); chk("R10 ack not writable, R8 dual low", v, 32'h0010_0010);
    wr(12'h1FC, 32'h0000_001E); wait_n(1);
    rd(12'h1FC, v); chk("R9 hsk restored", v, 32'h001E_001E);

    // R12 R2 random stimulus
    s_sw = pwr_sw_en; s_iso = iso_en; s_hs = hsk_req_n;
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      logic [31:0] w;
      a = 12'($urandom);
      w = $urandom;
      if (i % 10 == 0) begin
        wr(12'h0EC, w); rd(12'h0EC, v); chk("R2 random map", v, exp_map(w));
      end else if (!is_defined(a)) begin
        wr(a, w); rd(a, v); chk("R12 undefined reads zero", v, 0);
        chk("R12 no output change", {20'd0, s_sw, s_iso, s_hs},
            {20'd0, pwr_sw_en, iso_en, hsk_req_n});
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule